// File: doc/BRIEF.md
# True Dual-Port Block Memory with Selectable Write Behaviour

This block is an 18 Kbit synchronous memory with two fully independent ports. Each port has its own clock, enable, write enable, synchronous output clear, address, data and parity inputs, and registered data and parity outputs. A single width parameter picks one of six aspect ratios for both ports. The address width and depth follow from that choice. The widths of 9, 18 and 36 bits split each word into data bytes plus one parity bit per byte.

Every write on a port also reads on that port in the same cycle. A per-port mode parameter selects what the output register captures during that write. In write-first mode it captures the new word. In read-first mode it captures the word that was stored before the write. Both ports address one shared storage array, so a word written through one port can be read through the other. Writing the same location from both ports in overlapping cycles leaves the stored value undefined.

Top module: `tdp_bram`

## Requirements
- R1: `PORT_WIDTH` takes one of 1, 2, 4, 9, 18 or 36. The resulting depth is 16384, 8192, 4096, 2048, 1024 or 512, and the address is 14, 13, 12, 11, 10 or 9 bits wide. Any other width stops elaboration.
- R2: At widths 9, 18 and 36 a word holds 8, 16 or 32 data bits plus 1, 2 or 4 parity bits. Parity bit k travels with data byte k. Parity is stored and returned alongside the data, independently of the data's value. At widths 1, 2 and 4 the parity output is driven to zero.
- R3: With enable high and write enable low, the clock edge loads the word at the address into the output register. The word appears at the outputs right after that edge.
- R4: With enable and write enable both high, the clock edge stores the data and parity inputs at the address. Other addresses keep their contents.
- R5: In write-first mode, the edge that performs a write also loads the written data and parity into that port's output register.
- R6: In read-first mode, the edge that performs a write loads that port's output register with the word held at the address before the write.
- R7: With enable low, a port stores nothing, whatever its write enable, and its output register keeps its value.
- R8: With enable high and the output clear high, the edge sets that port's data and parity outputs to zero. The clear does not alter the memory contents.
- R9: Both ports share one storage array and run from their own clocks. A word written through one port is read back through the other. Writes through the two ports to different addresses in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| rst_a | input | 1 | Port A synchronous output clear |
| addr_a | input | AW | Port A word address |
| din_a | input | DW | Port A write data |
| pin_a | input | PPW | Port A write parity (unused when the width has no parity) |
| dout_a | output | DW | Port A registered read data |
| pout_a | output | PPW | Port A registered read parity |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| rst_b | input | 1 | Port B synchronous output clear |
| addr_b | input | AW | Port B word address |
| din_b | input | DW | Port B write data |
| pin_b | input | PPW | Port B write parity (unused when the width has no parity) |
| dout_b | output | DW | Port B registered read data |
| pout_b | output | PPW | Port B registered read parity |

## Verification
Each port result is due on the first rising edge at which the operation is presented: a read, a write-first or read-first echo, an output clear and a held output all appear there, with one register of latency. The bench changes inputs one nanosecond after a rising edge and samples the outputs one nanosecond after the next rising edge, so each check sees exactly the result of that one operation. Cross-port results take a write edge on one port and then a read edge on the other. Such a word is therefore checked on the second edge after it was written. The bench sweeps every address at the default 36-bit width.

// File: rtl/tdp_bram_pkg.sv
package tdp_bram_pkg;

   typedef enum logic {
      WR_FIRST = 1'b0,
      RD_FIRST = 1'b1
   } wr_mode_e;

   localparam int unsigned DATA_CAPACITY = 16384;

   function automatic bit legal_width(int unsigned w);
      return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18) || (w == 36);
   endfunction

   function automatic int unsigned data_bits(int unsigned w);
      case (w)
         9:       return 8;
         18:      return 16;
         36:      return 32;
         default: return w;
      endcase
   endfunction

   function automatic int unsigned parity_bits(int unsigned w);
      return w - data_bits(w);
   endfunction

   function automatic int unsigned parity_port_bits(int unsigned w);
      return (parity_bits(w) == 0) ? 1 : parity_bits(w);
   endfunction

   function automatic int unsigned word_depth(int unsigned w);
      return DATA_CAPACITY / data_bits(w);
   endfunction

endpackage

// File: rtl/tdp_word_pack.sv
module tdp_word_pack #(
   parameter int unsigned DW  = 32,
   parameter int unsigned PW  = 4,
   parameter int unsigned PPW = 4,
   localparam int unsigned WW = DW + PW
) (
   input  logic [DW-1:0]  din,
   input  logic [PPW-1:0] pin,
   output logic [WW-1:0]  wword,
   input  logic [WW-1:0]  rword,
   output logic [DW-1:0]  dout,
   output logic [PPW-1:0] pout
);

   generate
      if (PW == 0) begin : g_no_par
         logic unused_pin;
         assign unused_pin = ^pin;
         assign wword      = din;
         assign dout       = rword[DW-1:0];
         assign pout       = '0;
      end else begin : g_par
         assign wword = {pin[PW-1:0], din};
         assign dout  = rword[DW-1:0];
         assign pout  = rword[WW-1:DW];
      end
   endgenerate

endmodule

// File: rtl/tdp_port.sv
module tdp_port
   import tdp_bram_pkg::*;
#(
   parameter int unsigned WW    = 36,
   parameter int unsigned DEPTH = 512,
   parameter wr_mode_e    MODE  = WR_FIRST,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic          clr,
   input  logic [AW-1:0] addr,
   input  logic [WW-1:0] wword,
   input  logic [WW-1:0] peer_at_mine,
   input  logic [AW-1:0] peer_addr,
   output logic [WW-1:0] own_at_peer,
   output logic [AW-1:0] addr_out,
   output logic [WW-1:0] rword
);

   logic [WW-1:0] bank [DEPTH];
   logic [WW-1:0] stored;
   logic [WW-1:0] write_echo;

   initial begin
      for (int i = 0; i < DEPTH; i++) bank[i] = '0;
   end

   assign addr_out    = addr;
   assign own_at_peer = bank[peer_addr];
   assign stored      = bank[addr] ^ peer_at_mine;

   generate
      if (MODE == WR_FIRST) begin : g_wfirst
         assign write_echo = wword;
      end else begin : g_rfirst
         assign write_echo = stored;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (en && we) bank[addr] <= wword ^ peer_at_mine;
   end

   always_ff @(posedge clk) begin
      if (en) begin
         if (clr)     rword <= '0;
         else if (we) rword <= write_echo;
         else         rword <= stored;
      end
   end

endmodule

// File: rtl/tdp_bram.sv
module tdp_bram
   import tdp_bram_pkg::*;
#(
   parameter int unsigned PORT_WIDTH = 36,
   parameter wr_mode_e    MODE_A     = WR_FIRST,
   parameter wr_mode_e    MODE_B     = RD_FIRST,
   localparam int unsigned DW    = data_bits(PORT_WIDTH),
   localparam int unsigned PW    = parity_bits(PORT_WIDTH),
   localparam int unsigned PPW   = parity_port_bits(PORT_WIDTH),
   localparam int unsigned DEPTH = word_depth(PORT_WIDTH),
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic           clk_a,
   input  logic           en_a,
   input  logic           we_a,
   input  logic           rst_a,
   input  logic [AW-1:0]  addr_a,
   input  logic [DW-1:0]  din_a,
   input  logic [PPW-1:0] pin_a,
   output logic [DW-1:0]  dout_a,
   output logic [PPW-1:0] pout_a,
   input  logic           clk_b,
   input  logic           en_b,
   input  logic           we_b,
   input  logic           rst_b,
   input  logic [AW-1:0]  addr_b,
   input  logic [DW-1:0]  din_b,
   input  logic [PPW-1:0] pin_b,
   output logic [DW-1:0]  dout_b,
   output logic [PPW-1:0] pout_b
);

   localparam int unsigned WW = DW + PW;

   generate
      if (!legal_width(PORT_WIDTH)) begin : g_bad_width
         $error("tdp_bram: PORT_WIDTH %0d is not an allowed aspect ratio", PORT_WIDTH);
      end
      if (DEPTH * DW != DATA_CAPACITY) begin : g_bad_depth
         $error("tdp_bram: depth %0d does not match width %0d", DEPTH, DW);
      end
   endgenerate

   logic [WW-1:0] wword_a, wword_b;
   logic [WW-1:0] rword_a, rword_b;
   logic [WW-1:0] a_at_b, b_at_a;
   logic [AW-1:0] a_addr_seen, b_addr_seen;

   tdp_word_pack #(.DW(DW), .PW(PW), .PPW(PPW)) u_pack_a (
      .din  (din_a),
      .pin  (pin_a),
      .wword(wword_a),
      .rword(rword_a),
      .dout (dout_a),
      .pout (pout_a)
   );

   tdp_word_pack #(.DW(DW), .PW(PW), .PPW(PPW)) u_pack_b (
      .din  (din_b),
      .pin  (pin_b),
      .wword(wword_b),
      .rword(rword_b),
      .dout (dout_b),
      .pout (pout_b)
   );

   tdp_port #(.WW(WW), .DEPTH(DEPTH), .MODE(MODE_A)) u_port_a (
      .clk         (clk_a),
      .en          (en_a),
      .we          (we_a),
      .clr         (rst_a),
      .addr        (addr_a),
      .wword       (wword_a),
      .peer_at_mine(b_at_a),
      .peer_addr   (b_addr_seen),
      .own_at_peer (a_at_b),
      .addr_out    (a_addr_seen),
      .rword       (rword_a)
   );

   tdp_port #(.WW(WW), .DEPTH(DEPTH), .MODE(MODE_B)) u_port_b (
      .clk         (clk_b),
      .en          (en_b),
      .we          (we_b),
      .clr         (rst_b),
      .addr        (addr_b),
      .wword       (wword_b),
      .peer_at_mine(a_at_b),
      .peer_addr   (a_addr_seen),
      .own_at_peer (b_at_a),
      .addr_out    (b_addr_seen),
      .rword       (rword_b)
   );

endmodule

// File: rtl/tdp_bram_chk.sv
module tdp_bram_chk
   import tdp_bram_pkg::*;
#(
   parameter int unsigned PORT_WIDTH = 36,
   parameter wr_mode_e    MODE_A     = WR_FIRST,
   parameter wr_mode_e    MODE_B     = RD_FIRST,
   localparam int unsigned DW    = data_bits(PORT_WIDTH),
   localparam int unsigned PW    = parity_bits(PORT_WIDTH),
   localparam int unsigned PPW   = parity_port_bits(PORT_WIDTH),
   localparam int unsigned AW    = $clog2(word_depth(PORT_WIDTH))
) (
   input logic           clk_a,
   input logic           en_a,
   input logic           we_a,
   input logic           rst_a,
   input logic [AW-1:0]  addr_a,
   input logic [DW-1:0]  din_a,
   input logic [PPW-1:0] pin_a,
   input logic [DW-1:0]  dout_a,
   input logic [PPW-1:0] pout_a,
   input logic           clk_b,
   input logic           en_b,
   input logic           we_b,
   input logic           rst_b,
   input logic [AW-1:0]  addr_b,
   input logic [DW-1:0]  din_b,
   input logic [PPW-1:0] pin_b,
   input logic [DW-1:0]  dout_b,
   input logic [PPW-1:0] pout_b
);

   logic started_a = 1'b0;
   logic started_b = 1'b0;
   logic unused_chk;
   logic [PPW-1:0] par_mask;

   assign unused_chk = ^{addr_a, addr_b, din_a, din_b, pin_a, pin_b, we_a, we_b};
   assign par_mask   = (PW == 0) ? '0 : '1;

   always_ff @(posedge clk_a) started_a <= 1'b1;
   always_ff @(posedge clk_b) started_b <= 1'b1;

   AST_A_IDLE_HOLD: assert property (@(posedge clk_a) disable iff (!started_a)
      !en_a |=> $stable({pout_a, dout_a}));  // R7
   AST_B_IDLE_HOLD: assert property (@(posedge clk_b) disable iff (!started_b)
      !en_b |=> $stable({pout_b, dout_b}));  // R7
   AST_A_CLEAR_ZERO: assert property (@(posedge clk_a) disable iff (!started_a)
      (en_a && rst_a) |=> (dout_a == '0 && pout_a == '0));  // R8
   AST_B_CLEAR_ZERO: assert property (@(posedge clk_b) disable iff (!started_b)
      (en_b && rst_b) |=> (dout_b == '0 && pout_b == '0));  // R8

   generate
      if (MODE_A == WR_FIRST) begin : g_wf_a
         AST_A_WRITE_ECHO: assert property (@(posedge clk_a) disable iff (!started_a)
            (en_a && we_a && !rst_a) |=>
               (dout_a == $past(din_a) && pout_a == ($past(pin_a) & par_mask)));  // R5
      end
      if (MODE_B == WR_FIRST) begin : g_wf_b
         AST_B_WRITE_ECHO: assert property (@(posedge clk_b) disable iff (!started_b)
            (en_b && we_b && !rst_b) |=>
               (dout_b == $past(din_b) && pout_b == ($past(pin_b) & par_mask)));  // R5
      end
   endgenerate

endmodule

bind tdp_bram tdp_bram_chk #(
   .PORT_WIDTH(PORT_WIDTH),
   .MODE_A    (MODE_A),
   .MODE_B    (MODE_B)
) u_chk (.*);

// File: tb/tdp_bram_bench.sv
module tdp_bram_bench;

   localparam int DW = 32;
   localparam int PW = 4;
   localparam int AW = 9;
   localparam int NW = 512;

   logic          clk = 1'b0;
   logic          en_a, we_a, rst_a, en_b, we_b, rst_b;
   logic [AW-1:0] addr_a, addr_b;
   logic [DW-1:0] din_a, din_b, dout_a, dout_b;
   logic [PW-1:0] pin_a, pin_b, pout_a, pout_b;

   int n_vec  = 0;
   int n_bad  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   tdp_bram u_tdp_bram (
      .clk_a(clk), .en_a(en_a), .we_a(we_a), .rst_a(rst_a), .addr_a(addr_a),
      .din_a(din_a), .pin_a(pin_a), .dout_a(dout_a), .pout_a(pout_a),
      .clk_b(clk), .en_b(en_b), .we_b(we_b), .rst_b(rst_b), .addr_b(addr_b),
      .din_b(din_b), .pin_b(pin_b), .dout_b(dout_b), .pout_b(pout_b)
   );

   function automatic logic [DW-1:0] pat1(int a);
      return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   function automatic logic [DW-1:0] pat2(int a);
      return ~pat1(a) + a;
   endfunction

   function automatic logic [DW-1:0] pat3(int a);
      return {a[15:0], ~a[15:0]} ^ 32'hC3C3_3C3C;
   endfunction

   // parity bit k covers data byte k (R2)
   function automatic logic [PW-1:0] par(logic [DW-1:0] d);
      return {^d[31:24], ^d[23:16], ^d[15:8], ^d[7:0]};
   endfunction

   task automatic chk(string tag, logic [DW+PW-1:0] act, logic [DW+PW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      en_a = 0; we_a = 0; rst_a = 0; en_b = 0; we_b = 0; rst_b = 0;
   endtask

   initial begin
      idle();
      addr_a = '0; addr_b = '0; din_a = '0; din_b = '0; pin_a = '0; pin_b = '0;
      tick();

      // R1: address width for the default 36-bit ratio
      chk("R1 address width", 36'($bits(addr_a)), 36'(AW));

      // R8: output clear gives a known zero starting state
      en_a = 1; rst_a = 1; en_b = 1; rst_b = 1;
      tick();
      chk("R8 clear A", {pout_a, dout_a}, '0);
      chk("R8 clear B", {pout_b, dout_b}, '0);
      idle();

      // R4 R5 R2: fill every word through A (write-first echo)
      for (int a = 0; a < NW; a++) begin
         en_a = 1; we_a = 1; addr_a = AW'(a); din_a = pat1(a); pin_a = par(pat1(a));
         tick();
         chk("R5 write-first echo", {pout_a, dout_a}, {par(pat1(a)), pat1(a)});
      end
      idle();

      // R3 R9 R2: read all through B
      for (int a = 0; a < NW; a++) begin
         en_b = 1; addr_b = AW'(a);
         tick();
         chk("R3 R9 read across ports", {pout_b, dout_b}, {par(pat1(a)), pat1(a)});
      end
      idle();

      // R6: read-first writes through B on the low 64 words
      for (int a = 0; a < 64; a++) begin
         en_b = 1; we_b = 1; addr_b = AW'(a); din_b = pat2(a); pin_b = par(pat2(a));
         tick();
         chk("R6 read-first echo", {pout_b, dout_b}, {par(pat1(a)), pat1(a)});
      end
      idle();

      // R4: new words visible through A, neighbours untouched
      for (int a = 0; a < 128; a++) begin
         en_a = 1; addr_a = AW'(a);
         tick();
         if (a < 64) chk("R4 stored word", {pout_a, dout_a}, {par(pat2(a)), pat2(a)});
         else        chk("R4 untouched word", {pout_a, dout_a}, {par(pat1(a)), pat1(a)});
      end
      idle();

      // R2: parity stored independently of data value
      en_a = 1; we_a = 1; addr_a = 9'd3; din_a = 32'h0000_0000; pin_a = 4'hA;
      tick();
      idle();
      en_b = 1; addr_b = 9'd3;
      tick();
      chk("R2 parity kept apart", {pout_b, dout_b}, {4'hA, 32'h0});
      idle();

      // R7: port A disabled with write enable high
      en_a = 1; addr_a = 9'd5;
      tick();
      en_a = 0; we_a = 1; addr_a = 9'd9; din_a = 32'hDEAD_BEEF; pin_a = 4'hF;
      tick();
      chk("R7 A output held", {pout_a, dout_a}, {par(pat2(5)), pat2(5)});
      tick();
      chk("R7 A output held again", {pout_a, dout_a}, {par(pat2(5)), pat2(5)});
      idle();
      en_a = 1; addr_a = 9'd9;
      tick();
      chk("R7 A no write while off", {pout_a, dout_a}, {par(pat2(9)), pat2(9)});
      idle();

      // R7: port B disabled with write enable high
      en_b = 1; addr_b = 9'd300;
      tick();
      en_b = 0; we_b = 1; addr_b = 9'd301; din_b = 32'h1234_5678; pin_b = 4'h0;
      tick();
      chk("R7 B output held", {pout_b, dout_b}, {par(pat1(300)), pat1(300)});
      idle();
      en_b = 1; addr_b = 9'd301;
      tick();
      chk("R7 B no write while off", {pout_b, dout_b}, {par(pat1(301)), pat1(301)});
      idle();

      // R8: clear leaves the memory alone
      en_a = 1; addr_a = 9'd7;
      tick();
      chk("R8 before clear", {pout_a, dout_a}, {par(pat2(7)), pat2(7)});
      rst_a = 1;
      tick();
      chk("R8 clear zeroes A", {pout_a, dout_a}, '0);
      rst_a = 0;
      tick();
      chk("R8 memory intact", {pout_a, dout_a}, {par(pat2(7)), pat2(7)});
      idle();

      // R9: simultaneous writes to different addresses
      for (int k = 0; k < 8; k++) begin
         int xa, xb;
         xa = 100 + k; xb = 400 + k;
         en_a = 1; we_a = 1; addr_a = AW'(xa); din_a = pat3(xa); pin_a = par(pat3(xa));
         en_b = 1; we_b = 1; addr_b = AW'(xb); din_b = pat3(xb); pin_b = par(pat3(xb));
         tick();
         chk("R9 R5 A echo", {pout_a, dout_a}, {par(pat3(xa)), pat3(xa)});
         chk("R9 R6 B old word", {pout_b, dout_b}, {par(pat1(xb)), pat1(xb)});
         we_a = 0; we_b = 0; addr_a = AW'(xb); addr_b = AW'(xa);
         tick();
         chk("R9 A sees B write", {pout_a, dout_a}, {par(pat3(xb)), pat3(xb)});
         chk("R9 B sees A write", {pout_b, dout_b}, {par(pat3(xa)), pat3(xa)});
         idle();
      end

      // R1: last address of the 512-word depth
      en_b = 1; we_b = 1; addr_b = 9'd511; din_b = 32'hA5A5_A5A5; pin_b = 4'h3;
      tick();
      idle();
      en_a = 1; addr_a = 9'd511;
      tick();
      chk("R1 top address", {pout_a, dout_a}, {4'h3, 32'hA5A5_A5A5});
      idle();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule